// File: doc/BRIEF.md
# I2C Packet Header Decoder

This block sits between a word-wide transmit FIFO and a bit-level I2C engine. It pops the three-word header that opens every transfer and turns it into one command for the engine: the target address, the transfer direction, the bus options and the way the transfer ends. The engine accepts that command through a valid/ready handshake.

For a write, the block then unpacks the payload words that follow the header into a byte stream. Each word carries four bytes, lowest byte first. The last word may hold only one to three valid bytes, and its unused lanes are dropped. A read carries no payload in the FIFO, so the decoder goes straight back to waiting for the next header. A word that should open a packet but lacks the I2C protocol flag makes the decoder throw the whole packet away and flag an error.

Top module: `i2c_hdr_decoder`

## Requirements
- R1: A FIFO word is consumed on a clock edge only when `fifo_pop` and `fifo_valid` are both high. Words are consumed strictly in order, and the block never pops while it presents a command or a byte.
- R2: The command carries these fields. `cmd_len_m1` is word 1 bits [11:0], and the upper bits of word 1 are ignored. `cmd_pkt_id` is word 0 bits [23:16] and `cmd_ctrl_id` is word 0 bits [15:12]. From word 2: bit 22 gives `cmd_hs`, bit 21 `cmd_nak_cont`, bit 20 `cmd_start_byte`, bit 19 `cmd_read` and bit 17 `cmd_irq_en`. Word 0 bits [31:28] are not used.
- R3: When word 2 bit 18 is set, `cmd_ten_bit` is 1 and `cmd_addr` is word 2 bits [9:0]. Otherwise `cmd_addr` is word 2 bits [7:1], zero-extended.
- R4: `cmd_end` encodes how the transfer ends. It is 1 (repeated start) when word 2 bit 16 is set, and bit 16 wins over bit 15. It is 2 (continue with no stop or restart) when only bit 15 is set. It is 0 (stop) when neither bit is set.
- R5: Once `cmd_valid` rises, it and every command field stay unchanged until a cycle with `cmd_ready` high.
- R6: After a write command is accepted, exactly `cmd_len_m1`+1 bytes are offered on `tx_byte`, lowest byte of each word first. Each byte is held until `tx_ready`, and `tx_last` marks the final byte. The unused lanes of a partial last word are never offered, and the next FIFO word is parsed as a new word 0.
- R7: A read packet pops no words after its three header words.
- R8: `done` is a one-cycle pulse. For a write it comes in the cycle after the last byte is accepted; for a read it comes in the cycle after the command is accepted.
- R9: A word 0 with bit 4 clear produces a one-cycle `err` pulse in the cycle after it is popped. That packet then produces no command, no bytes and no `done`. Its words 1 and 2 are popped and discarded, and for a write its ceil((len_m1+1)/4) payload words are discarded as well.
- R10: While reset is held, `cmd_valid`, `tx_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_valid | input | 1 | FIFO head word present |
| fifo_data | input | 8*BPW | FIFO head word |
| fifo_pop | output | 1 | Consume head word this cycle |
| cmd_valid | output | 1 | Command offered to engine |
| cmd_ready | input | 1 | Engine takes command |
| cmd_addr | output | 10 | Target address |
| cmd_ten_bit | output | 1 | 10-bit addressing |
| cmd_read | output | 1 | Read transfer |
| cmd_hs | output | 1 | High-speed transfer |
| cmd_nak_cont | output | 1 | Continue on NAK |
| cmd_start_byte | output | 1 | Send start byte first |
| cmd_irq_en | output | 1 | Per-packet interrupt enable |
| cmd_end | output | 2 | End mode: 0 stop, 1 restart, 2 continue |
| cmd_len_m1 | output | LEN_W | Payload length minus one |
| cmd_pkt_id | output | 8 | Packet id |
| cmd_ctrl_id | output | 4 | Controller id |
| tx_valid | output | 1 | Payload byte offered |
| tx_ready | input | 1 | Engine takes byte |
| tx_byte | output | 8 | Payload byte |
| tx_last | output | 1 | Final payload byte |
| done | output | 1 | Packet finished pulse |
| err | output | 1 | Packet rejected pulse |

## Verification
A command or a byte is due in the same cycle as its handshake, because both are offered straight from registers. `done` and `err` are due exactly one cycle after the accepting edge or the popping edge. The bench works out each handshake and pop half a cycle before the edge that acts on it. At the next falling edge it expects `done` or `err` high precisely when that edge ended a packet or popped a flagless word 0, and low in every other cycle. Random FIFO gaps and random ready stalls move these cycles around from packet to packet, so each check is tied to the handshake that caused it and not to a fixed delay.

// File: rtl/i2c_hdr_pkg.sv
// Shared constants and types for the I2C packet header decoder.
// Assumes the 32-bit header layout described in the brief.
package i2c_hdr_pkg;
    localparam int W0_PROTO_BIT  = 4;
    localparam int W0_PKTID_LSB  = 16;
    localparam int W0_PKTID_W    = 8;
    localparam int W0_CTRLID_LSB = 12;
    localparam int W0_CTRLID_W   = 4;

    localparam int W2_HS_BIT     = 22;
    localparam int W2_NAKC_BIT   = 21;
    localparam int W2_SBYTE_BIT  = 20;
    localparam int W2_READ_BIT   = 19;
    localparam int W2_TEN_BIT    = 18;
    localparam int W2_IRQ_BIT    = 17;
    localparam int W2_RSTART_BIT = 16;
    localparam int W2_CONT_BIT   = 15;
    localparam int W2_ADDR7_LSB  = 1;
    localparam int ADDR_W        = 10;

    typedef enum logic [1:0] {
        END_STOP     = 2'd0,
        END_RESTART  = 2'd1,
        END_CONTINUE = 2'd2
    } end_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ten_bit;
        logic              read;
        logic              hs;
        logic              nak_cont;
        logic              start_byte;
        logic              irq_en;
        end_mode_e         end_mode;
    } ctl_t;
endpackage

// File: rtl/i2c_hdr_ctl_decode.sv
// Control-word decoder: turns header word 2 into engine control fields.
// Purely combinational; assumes the word is held stable by the caller.
module i2c_hdr_ctl_decode
    import i2c_hdr_pkg::*;
(
    input  logic [31:0] ctl_word,
    output ctl_t        ctl
);
    // Field extraction, address placement and end-mode priority.
    always_comb begin
        ctl.ten_bit    = ctl_word[W2_TEN_BIT];
        ctl.read       = ctl_word[W2_READ_BIT];
        ctl.hs         = ctl_word[W2_HS_BIT];
        ctl.nak_cont   = ctl_word[W2_NAKC_BIT];
        ctl.start_byte = ctl_word[W2_SBYTE_BIT];
        ctl.irq_en     = ctl_word[W2_IRQ_BIT];
        if (ctl_word[W2_TEN_BIT])
            ctl.addr = ctl_word[ADDR_W-1:0];
        else
            ctl.addr = {3'b000, ctl_word[W2_ADDR7_LSB +: 7]};
        if (ctl_word[W2_RSTART_BIT])
            ctl.end_mode = END_RESTART;
        else if (ctl_word[W2_CONT_BIT])
            ctl.end_mode = END_CONTINUE;
        else
            ctl.end_mode = END_STOP;
    end
endmodule

// File: rtl/i2c_payload_unpacker.sv
// Payload unpacker: tracks the bytes left in a packet and the valid lanes of
// the current word. It shifts bytes out lowest first and can also drop
// whole words. Assumes at most one control input is high per cycle.
module i2c_payload_unpacker #(
    parameter int BPW   = 4,
    parameter int LEN_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               len_load,
    input  logic [LEN_W-1:0]   len_m1,
    input  logic               word_load,
    input  logic               word_drop,
    input  logic [8*BPW-1:0]   word_in,
    input  logic               byte_take,
    output logic [7:0]         cur_byte,
    output logic               last_byte,
    output logic               last_in_word,
    output logic               last_word
);
    localparam int WORD_W = 8 * BPW;
    localparam int REM_W  = LEN_W + 1;
    localparam int LANE_W = $clog2(BPW + 1);

    logic [REM_W-1:0]  rem_q;
    logic [WORD_W-1:0] word_q;
    logic [LANE_W-1:0] lanes_q;
    logic [LANE_W-1:0] chunk;

    // Number of payload bytes the next word carries.
    always_comb begin
        if (rem_q >= REM_W'(BPW)) chunk = LANE_W'(BPW);
        else                      chunk = rem_q[LANE_W-1:0];
    end

    // Byte counter, word holding register and lane counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            word_q  <= '0;
            lanes_q <= '0;
        end else if (len_load) begin
            rem_q   <= REM_W'(len_m1) + REM_W'(1);
        end else if (word_load) begin
            word_q  <= word_in;
            lanes_q <= chunk;
        end else if (word_drop) begin
            rem_q   <= rem_q - REM_W'(chunk);
        end else if (byte_take) begin
            word_q  <= word_q >> 8;
            rem_q   <= rem_q - REM_W'(1);
            lanes_q <= lanes_q - LANE_W'(1);
        end
    end

    assign cur_byte     = word_q[7:0];
    assign last_byte    = (rem_q == REM_W'(1));
    assign last_in_word = (lanes_q == LANE_W'(1));
    assign last_word    = (rem_q <= REM_W'(BPW));

    // R6
    no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> (rem_q != '0) && (lanes_q != '0));
    // R9
    drop_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_drop |-> (rem_q != '0));
endmodule

// File: rtl/i2c_hdr_decoder.sv
// I2C packet header decoder top. Pops the three header words, offers one
// command to the engine, then streams write payload bytes. Packets whose
// word 0 lacks the protocol flag are consumed silently with an error pulse.
// Assumes a show-ahead FIFO: fifo_data is the head word while fifo_valid.
module i2c_hdr_decoder
    import i2c_hdr_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int BPW   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_valid,
    input  logic [8*BPW-1:0]   fifo_data,
    output logic               fifo_pop,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [9:0]         cmd_addr,
    output logic               cmd_ten_bit,
    output logic               cmd_read,
    output logic               cmd_hs,
    output logic               cmd_nak_cont,
    output logic               cmd_start_byte,
    output logic               cmd_irq_en,
    output logic [1:0]         cmd_end,
    output logic [LEN_W-1:0]   cmd_len_m1,
    output logic [7:0]         cmd_pkt_id,
    output logic [3:0]         cmd_ctrl_id,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_byte,
    output logic               tx_last,
    output logic               done,
    output logic               err
);
    typedef enum logic [2:0] {
        S_W0, S_W1, S_W2, S_CMD, S_LOAD, S_BYTES
    } state_e;

    state_e                  state_q, state_d;
    logic                    drop_q;
    logic [W0_PKTID_W-1:0]   pkt_id_q;
    logic [W0_CTRLID_W-1:0]  ctrl_id_q;
    logic [LEN_W-1:0]        len_q;
    logic [31:0]             w2_q;
    logic                    done_q, err_q;
    ctl_t                    ctl;
    logic                    take, cmd_fire, tx_fire;
    logic                    last_byte, last_in_word, last_word;
    logic [7:0]              cur_byte;

    i2c_hdr_ctl_decode i_ctl (
        .ctl_word (w2_q),
        .ctl      (ctl)
    );

    i2c_payload_unpacker #(.BPW(BPW), .LEN_W(LEN_W)) i_unpack (
        .clk          (clk),
        .rst_n        (rst_n),
        .len_load     (take && state_q == S_W1),
        .len_m1       (fifo_data[LEN_W-1:0]),
        .word_load    (take && state_q == S_LOAD && !drop_q),
        .word_drop    (take && state_q == S_LOAD && drop_q),
        .word_in      (fifo_data),
        .byte_take    (tx_fire),
        .cur_byte     (cur_byte),
        .last_byte    (last_byte),
        .last_in_word (last_in_word),
        .last_word    (last_word)
    );

    // Handshake qualifiers.
    always_comb begin
        take = fifo_valid && (state_q == S_W0 || state_q == S_W1 ||
                              state_q == S_W2 || state_q == S_LOAD);
        cmd_fire = (state_q == S_CMD) && cmd_ready;
        tx_fire  = (state_q == S_BYTES) && tx_ready;
    end

    // Next-state selection for header, command and payload phases.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_W0:    if (take) state_d = S_W1;
            S_W1:    if (take) state_d = S_W2;
            S_W2:    if (take) begin
                         if (!drop_q)                     state_d = S_CMD;
                         else if (fifo_data[W2_READ_BIT]) state_d = S_W0;
                         else                             state_d = S_LOAD;
                     end
            S_CMD:   if (cmd_fire) state_d = ctl.read ? S_W0 : S_LOAD;
            S_LOAD:  if (take) begin
                         if (!drop_q)        state_d = S_BYTES;
                         else if (last_word) state_d = S_W0;
                     end
            S_BYTES: if (tx_fire) begin
                         if (last_byte)         state_d = S_W0;
                         else if (last_in_word) state_d = S_LOAD;
                     end
            default: state_d = S_W0;
        endcase
    end

    // State, captured header fields and the done/err pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_W0;
            drop_q    <= 1'b0;
            pkt_id_q  <= '0;
            ctrl_id_q <= '0;
            len_q     <= '0;
            w2_q      <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (cmd_fire && ctl.read) || (tx_fire && last_byte);
            err_q   <= 1'b0;
            if (take && state_q == S_W0) begin
                drop_q    <= !fifo_data[W0_PROTO_BIT];
                err_q     <= !fifo_data[W0_PROTO_BIT];
                pkt_id_q  <= fifo_data[W0_PKTID_LSB +: W0_PKTID_W];
                ctrl_id_q <= fifo_data[W0_CTRLID_LSB +: W0_CTRLID_W];
            end
            if (take && state_q == S_W1) len_q <= fifo_data[LEN_W-1:0];
            if (take && state_q == S_W2) w2_q  <= fifo_data[31:0];
        end
    end

    assign fifo_pop       = take;
    assign cmd_valid      = (state_q == S_CMD);
    assign cmd_addr       = ctl.addr;
    assign cmd_ten_bit    = ctl.ten_bit;
    assign cmd_read       = ctl.read;
    assign cmd_hs         = ctl.hs;
    assign cmd_nak_cont   = ctl.nak_cont;
    assign cmd_start_byte = ctl.start_byte;
    assign cmd_irq_en     = ctl.irq_en;
    assign cmd_end        = ctl.end_mode;
    assign cmd_len_m1     = len_q;
    assign cmd_pkt_id     = pkt_id_q;
    assign cmd_ctrl_id    = ctrl_id_q;
    assign tx_valid       = (state_q == S_BYTES);
    assign tx_byte        = cur_byte;
    assign tx_last        = tx_valid && last_byte;
    assign done           = done_q;
    assign err            = err_q;

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) &&
        $stable(cmd_end) && $stable(cmd_len_m1) && $stable(cmd_read) &&
        $stable(cmd_pkt_id) && $stable(cmd_ctrl_id));
    // R6
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));
    // R1
    one_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_pop, cmd_valid, tx_valid}));
    // R8
    read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_read |=> done && !err);
    // R8
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> done);
    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: tb/test_i2c_hdr_decoder.sv
module test_i2c_hdr_decoder;
    localparam int NW = 8192;
    localparam int NB = 16384;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_valid = 1'b0;
    logic [31:0] fifo_data = '0;
    logic fifo_pop;
    logic cmd_valid, cmd_ready = 1'b0;
    logic [9:0] cmd_addr;
    logic cmd_ten_bit, cmd_read, cmd_hs, cmd_nak_cont, cmd_start_byte, cmd_irq_en;
    logic [1:0] cmd_end;
    logic [11:0] cmd_len_m1;
    logic [7:0] cmd_pkt_id;
    logic [3:0] cmd_ctrl_id;
    logic tx_valid, tx_ready = 1'b0;
    logic [7:0] tx_byte;
    logic tx_last, done, err;

    always #4 clk = ~clk;

    i2c_hdr_decoder i_i2c_hdr_decoder (
        .clk(clk), .rst_n(rst_n), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_ten_bit(cmd_ten_bit), .cmd_read(cmd_read),
        .cmd_hs(cmd_hs), .cmd_nak_cont(cmd_nak_cont), .cmd_start_byte(cmd_start_byte),
        .cmd_irq_en(cmd_irq_en), .cmd_end(cmd_end), .cmd_len_m1(cmd_len_m1),
        .cmd_pkt_id(cmd_pkt_id), .cmd_ctrl_id(cmd_ctrl_id), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_last(tx_last),
        .done(done), .err(err)
    );

    logic [31:0] fmem [NW];
    bit          bad_w0 [NW];
    logic [41:0] exp_cmd [256];
    logic [8:0]  exp_byte [NB];
    int nwords = 0, ncmd = 0, nbytes = 0, nbad = 0;
    int nchecks = 0, nfails = 0;
    int seed_sink;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected command from the three header words (requirements R2 R3 R4).
    function automatic logic [41:0] expect_cmd(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2);
        logic [9:0] a;
        logic [1:0] e;
        a = w2[18] ? w2[9:0] : {3'b000, w2[7:1]};
        e = w2[16] ? 2'd1 : (w2[15] ? 2'd2 : 2'd0);
        return {a, w2[18], w2[19], w2[22], w2[21], w2[20], w2[17], e,
                w1[11:0], w0[23:16], w0[15:12]};
    endfunction

    task automatic add_pkt(input bit bad, input bit rd, input int len, input logic [31:0] w2r);
        logic [31:0] w0, w1, w2, d;
        w0 = $urandom; w0[4] = !bad;
        w1 = $urandom; w1[11:0] = 12'(len - 1);
        w2 = w2r; w2[19] = rd;
        bad_w0[nwords] = bad;
        fmem[nwords] = w0; fmem[nwords+1] = w1; fmem[nwords+2] = w2;
        bad_w0[nwords+1] = 0; bad_w0[nwords+2] = 0;
        nwords += 3;
        if (bad) nbad++;
        else begin exp_cmd[ncmd] = expect_cmd(w0, w1, w2); ncmd++; end
        if (!rd) begin
            for (int i = 0; i < (len + 3) / 4; i++) begin
                d = $urandom;
                fmem[nwords] = d; bad_w0[nwords] = 0; nwords++;
                if (!bad)
                    for (int k = 0; k < 4; k++)
                        if (i*4 + k < len) begin
                            exp_byte[nbytes] = {(i*4 + k == len - 1), d[8*k +: 8]};
                            nbytes++;
                        end
            end
        end
    endtask

    function automatic logic [31:0] w2_with(logic [31:0] r, bit ten, bit rs, bit ct);
        logic [31:0] v;
        v = r; v[18] = ten; v[16] = rs; v[15] = ct;
        return v;
    endfunction

    int head = 0, ci = 0, bi = 0, ndone = 0, nerr = 0;
    bit pend_pop = 0, exp_done_next = 0, exp_err_next = 0, finished = 0;
    logic [41:0] act_cmd;

    initial begin
        seed_sink = $urandom(32'h1c2d_0457);
        // Directed corners: partial and full last words, end modes, address widths.
        add_pkt(0, 0, 1,  w2_with($urandom, 0, 1, 0));
        add_pkt(0, 0, 4,  w2_with($urandom, 0, 0, 1));
        add_pkt(0, 0, 5,  w2_with($urandom, 1, 1, 1));
        add_pkt(0, 0, 8,  w2_with($urandom, 1, 0, 0));
        add_pkt(0, 1, 7,  w2_with($urandom, 0, 0, 0));
        add_pkt(1, 0, 6,  $urandom);
        add_pkt(1, 1, 9,  $urandom);
        add_pkt(0, 1, 1,  w2_with($urandom, 1, 0, 1));
        add_pkt(0, 0, 3,  $urandom);
        for (int p = 0; p < 40; p++)
            add_pkt(($urandom % 100) < 15, $urandom % 2, 1 + $urandom % 16, $urandom);
        add_pkt(0, 0, 4096, $urandom);
        add_pkt(0, 0, 2, $urandom);

        // R10: reset state.
        repeat (4) @(negedge clk);
        #1;
        chk("R10 cmd_valid", cmd_valid, 0);
        chk("R10 tx_valid", tx_valid, 0);
        chk("R10 done", done, 0);
        chk("R10 err", err, 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 150000 && !finished; cyc++) begin
            @(negedge clk);
            if (pend_pop) head++;
            if (done || exp_done_next) chk("R8 done pulse", done, exp_done_next);
            if (err || exp_err_next)   chk("R9 err pulse", err, exp_err_next);
            if (done) ndone++;
            if (err) nerr++;
            if (ci == ncmd && bi == nbytes && head == nwords && ndone == ncmd && !exp_done_next)
                finished = 1;
            fifo_valid = (head < nwords) && (($urandom % 100) < 85);
            fifo_data  = fifo_valid ? fmem[head] : 32'h0;
            cmd_ready  = ($urandom % 100) < 65;
            tx_ready   = ($urandom % 100) < 70;
            #1;
            pend_pop = fifo_pop && fifo_valid;
            exp_err_next = pend_pop && bad_w0[head];
            exp_done_next = 0;
            if (cmd_valid && cmd_ready) begin
                act_cmd = {cmd_addr, cmd_ten_bit, cmd_read, cmd_hs, cmd_nak_cont,
                           cmd_start_byte, cmd_irq_en, cmd_end, cmd_len_m1,
                           cmd_pkt_id, cmd_ctrl_id};
                if (ci < ncmd) begin
                    // Stalled cmd_ready before acceptance also exercises R5 hold.
                    chk("R2 R3 R4 R5 command", act_cmd, exp_cmd[ci]);
                    exp_done_next = exp_cmd[ci][30];
                end else chk("R9 unexpected command", 1, 0);
                ci++;
            end
            if (tx_valid && tx_ready) begin
                if (bi < nbytes) begin
                    chk("R6 payload byte", {tx_last, tx_byte}, exp_byte[bi]);
                    exp_done_next = exp_byte[bi][8];
                end else chk("R7 R9 unexpected byte", 1, 0);
                bi++;
            end
        end
        fifo_valid = 0;
        repeat (4) begin
            @(negedge clk); #1;
            chk("R8 R9 no stray pulse", {done, err, cmd_valid, tx_valid}, 0);
        end
        chk("R1 R7 all words consumed", head, nwords);
        chk("R2 command count", ci, ncmd);
        chk("R6 byte count", bi, nbytes);
        chk("R8 done count", ndone, ncmd);
        chk("R9 err count", nerr, nbad);
        if (!finished) begin
            nchecks++; nfails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end
endmodule